// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block produces the refresh and power-management commands of an SDRAM controller. A programmable down-counter raises a refresh request at a fixed interval. The sequencer turns each request into an AUTO-REFRESH command. It never cuts into a host burst: a burst that has been granted runs until the host reports it done, and only then is the refresh issued. While a refresh or a power transition is running, the host sees a busy flag and its request is held off.

When the low-power policy is enabled, an idle memory is put into self-refresh after a timeout chosen by a 2-bit code. Entry takes two commands: PRECHARGE ALL, then SELF-REFRESH entry. If a host request arrives between the two, the entry is dropped and an AUTO-REFRESH is issued in its place. A request that arrives while the memory is in self-refresh triggers the exit command. CKE then goes high, and a fixed number of NOP cycles passes before the host is granted.

Top module: `sdram_refresh_seq`

## Requirements
- R1: Outside self-refresh, with no host traffic, AUTO-REFRESH commands come exactly `ref_period_i` cycles apart.
- R2: No AUTO-REFRESH is issued between a grant and the matching `done_i` pulse. A refresh that became due during the burst is issued two cycles after the cycle in which `done_i` is high.
- R3: During an AUTO-REFRESH and the `TRFC` cycles that follow it, `busy_o` is high and `grant_o` stays low. A request held over that time is granted `TRFC+1` cycles after the AUTO-REFRESH cycle (5 with the default parameters).
- R4: PRECHARGE ALL and SELF-REFRESH entry are issued only while `lp_mode_i` equals 2'b01. With any other value, CKE stays high through any length of idle time.
- R5: The entry delay is set by `lp_timeout_i`. Codes 00 and 11 give no wait, 01 gives 64 idle cycles and 10 gives 128. PRECHARGE ALL appears `wait+2` cycles after the `done_i` cycle.
- R6: SELF-REFRESH entry always follows PRECHARGE ALL in the next cycle, and CKE falls in the same cycle as the entry command.
- R7: If `req_i` is high in the PRECHARGE ALL cycle, the next command is AUTO-REFRESH instead of SELF-REFRESH entry.
- R8: In self-refresh, CKE is low and `busy_o` is high. A request causes SELF-REFRESH exit with CKE high in that cycle. The grant follows `TXSR+1` cycles after the exit command (9 with the default parameters).
- R9: Command codes are 000 NOP, 001 PRECHARGE ALL, 010 AUTO-REFRESH, 011 SELF-REFRESH entry and 100 SELF-REFRESH exit. No other code ever appears, and a non-NOP code never holds for two cycles in a row.
- R10: During reset, `cmd_o` is NOP, `cke_o` is high, and both `busy_o` and `grant_o` are low.
- R11: The idle count restarts at every access. An access that starts before the timeout has run out postpones entry to `wait+2` cycles after the later `done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held until granted |
| done_i | input | 1 | One-cycle pulse marking the end of the granted burst |
| ref_period_i | input | TW | Cycles between refresh requests |
| lp_mode_i | input | 2 | Low-power command; 01 enables self-refresh |
| lp_timeout_i | input | 2 | Self-refresh entry delay code |
| cmd_o | output | 3 | Command code, see R9 |
| cke_o | output | 1 | Clock-enable level to the memory |
| busy_o | output | 1 | Host request cannot be accepted now |
| grant_o | output | 1 | Request accepted this cycle |

## Verification
The refresh path runs under three patterns: an idle bus, which measures the raw interval, a request placed right on a refresh, which shows the busy hold-off and its length, and a burst longer than several intervals, which shows that a due refresh waits for `done_i`. The self-refresh path runs through each timeout code, including the reserved one. It also covers two accesses close together, which separates a counter that restarts from one that runs free. A request timed into the PRECHARGE ALL cycle shows whether the replacement happens. A final idle stretch with the policy off shows that entry depends on the mode field.

// File: rtl/sdram_ref_pkg.sv
`timescale 1ns/1ps
package sdram_ref_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'b000,
    CMD_PALL = 3'b001,
    CMD_AREF = 3'b010,
    CMD_SREN = 3'b011,
    CMD_SREX = 3'b100
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_XFER, ST_AREF, ST_RWAIT, ST_PALL,
    ST_SREN, ST_SLEEP, ST_SREX, ST_XWAIT
  } seq_st_e;

  localparam logic [1:0] LP_SELF_REFRESH = 2'b01;
endpackage

// File: rtl/sdr_ref_timer.sv
`timescale 1ns/1ps
module sdr_ref_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] period_i,
  input  logic          reload_i,
  output logic          tick_o
);
  logic [TW-1:0] cnt_q;

  assign tick_o = !reload_i && (cnt_q == TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_q <= '0;
    else if (reload_i || cnt_q == '0 || tick_o)  cnt_q <= period_i;
    else                                         cnt_q <= cnt_q - TW'(1);
  end
endmodule

// File: rtl/sdr_idle_timer.sv
`timescale 1ns/1ps
module sdr_idle_timer #(
  parameter int SHORT_WAIT = 64,
  parameter int LONG_WAIT  = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] code_i,
  input  logic       clear_i,
  output logic       expired_o
);
  localparam int CW = $clog2(LONG_WAIT + 1);

  logic [CW-1:0] cnt_q, lim;

  // 11 is reserved and falls back to immediate entry
  always_comb begin
    case (code_i)
      2'b01:   lim = CW'(SHORT_WAIT);
      2'b10:   lim = CW'(LONG_WAIT);
      default: lim = '0;
    endcase
  end

  assign expired_o = !clear_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (cnt_q < lim) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/sdram_refresh_seq.sv
`timescale 1ns/1ps
module sdram_refresh_seq
  import sdram_ref_pkg::*;
#(
  parameter int TW         = 16,
  parameter int TRFC       = 4,
  parameter int TXSR       = 8,
  parameter int IDLE_SHORT = 64,
  parameter int IDLE_LONG  = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          done_i,
  input  logic [TW-1:0] ref_period_i,
  input  logic [1:0]    lp_mode_i,
  input  logic [1:0]    lp_timeout_i,
  output logic [2:0]    cmd_o,
  output logic          cke_o,
  output logic          busy_o,
  output logic          grant_o
);
  localparam int WMAX = (TRFC > TXSR) ? TRFC : TXSR;
  localparam int WW   = $clog2(WMAX + 1);

  seq_st_e        state_q, state_d;
  logic [WW-1:0]  wcnt_q;
  logic           ref_pend_q, tick, idle_exp, asleep, lp_on;

  assign lp_on  = (lp_mode_i == LP_SELF_REFRESH);
  assign asleep = state_q inside {ST_SREN, ST_SLEEP, ST_SREX, ST_XWAIT};

  sdr_ref_timer #(.TW(TW)) u_ref_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (ref_period_i),
    .reload_i (asleep),
    .tick_o   (tick)
  );

  sdr_idle_timer #(.SHORT_WAIT(IDLE_SHORT), .LONG_WAIT(IDLE_LONG)) u_idle_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (lp_timeout_i),
    .clear_i   (state_q != ST_IDLE),
    .expired_o (idle_exp)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (ref_pend_q)              state_d = ST_AREF;
        else if (req_i)              state_d = ST_XFER;
        else if (lp_on && idle_exp)  state_d = ST_PALL;
      end
      ST_XFER:  if (done_i) state_d = ST_IDLE;
      ST_AREF:  state_d = ST_RWAIT;
      ST_RWAIT: if (wcnt_q == '0) state_d = ST_IDLE;
      // access seen between precharge and entry: refresh instead
      ST_PALL:  state_d = req_i ? ST_AREF : ST_SREN;
      ST_SREN:  state_d = ST_SLEEP;
      ST_SLEEP: if (req_i) state_d = ST_SREX;
      ST_SREX:  state_d = ST_XWAIT;
      ST_XWAIT: if (wcnt_q == '0) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wcnt_q     <= '0;
      ref_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ref_pend_q <= tick || (ref_pend_q && !(state_q inside {ST_AREF, ST_SREN}));
      if (state_q == ST_AREF)      wcnt_q <= WW'(TRFC - 1);
      else if (state_q == ST_SREX) wcnt_q <= WW'(TXSR - 1);
      else if (wcnt_q != '0)       wcnt_q <= wcnt_q - WW'(1);
    end
  end

  always_comb begin
    case (state_q)
      ST_PALL: cmd_o = CMD_PALL;
      ST_AREF: cmd_o = CMD_AREF;
      ST_SREN: cmd_o = CMD_SREN;
      ST_SREX: cmd_o = CMD_SREX;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign cke_o   = !(state_q inside {ST_SREN, ST_SLEEP});
  assign grant_o = (state_q == ST_IDLE) && !ref_pend_q && req_i;
  assign busy_o  = (state_q == ST_IDLE) ? ref_pend_q : (state_q != ST_XFER);
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
`timescale 1ns/1ps
module sdram_refresh_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       done_i,
  input logic [1:0] lp_mode_i,
  input logic [2:0] cmd_o,
  input logic       cke_o,
  input logic       busy_o,
  input logic       grant_o
);
  logic in_burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      in_burst_q <= 1'b0;
    else if (grant_o) in_burst_q <= 1'b1;
    else if (done_i)  in_burst_q <= 1'b0;
  end

  // R9
  legal_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o <= 3'd4);
  // R9
  one_cycle_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o != 3'd0 |=> cmd_o != $past(cmd_o));
  // R6
  entry_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd3 |-> $past(cmd_o) == 3'd1);
  // R6
  cke_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> cmd_o == 3'd3);
  // R8
  cke_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> cmd_o == 3'd4);
  // R3
  busy_on_refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd2 |-> busy_o && !grant_o);
  // R3
  grant_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> req_i && !busy_o);
  // R2
  no_refresh_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_burst_q |-> cmd_o != 3'd2);
  // R4
  pall_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd1 |-> $past(lp_mode_i) == 2'b01);
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .done_i    (done_i),
  .lp_mode_i (lp_mode_i),
  .cmd_o     (cmd_o),
  .cke_o     (cke_o),
  .busy_o    (busy_o),
  .grant_o   (grant_o)
);

// File: tb/sdram_refresh_seq_bench.sv
`timescale 1ns/1ps
module sdram_refresh_seq_bench;
  localparam int TW = 16, TRFC = 4, TXSR = 8;
  localparam logic [2:0] C_PALL = 3'b001, C_AREF = 3'b010, C_SREN = 3'b011, C_SREX = 3'b100;

  logic clk = 1'b0, rst_ni = 1'b0, req = 1'b0, done_s = 1'b0;
  logic [TW-1:0] period = '0;
  logic [1:0] lp_mode = 2'b00, lp_tmo = 2'b00;
  logic [2:0] cmd_o;
  logic cke_o, busy_o, grant_o;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int seen_at [8];
  bit cke_low_seen = 1'b0;
  logic [2:0] exp_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_refresh_seq #(.TW(TW), .TRFC(TRFC), .TXSR(TXSR)) u_sdram_refresh_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .done_i(done_s),
    .ref_period_i(period), .lp_mode_i(lp_mode), .lp_timeout_i(lp_tmo),
    .cmd_o(cmd_o), .cke_o(cke_o), .busy_o(busy_o), .grant_o(grant_o));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!cke_o) cke_low_seen = 1'b1;
      if (cmd_o != 3'b000) begin
        logic [2:0] e;
        seen_at[cmd_o] = cyc;
        if (cmd_o == C_SREX) chk(cke_o == 1'b1, "R8", "cke at exit", int'(cke_o), 1);
        if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected command", int'(cmd_o), 0);
        else begin
          e = exp_q.pop_front();
          chk(cmd_o == e, "R9", "command order", int'(cmd_o), int'(e));
        end
      end
    end
  end

  task automatic wait_cmd(input logic [2:0] c, output int at);
    int n = 0;
    do begin @(negedge clk); n++; end while (cmd_o != c && n < 5000);
    at = cyc;
    if (n >= 5000) chk(1'b0, "R9", "command timeout", 0, int'(c));
  endtask

  task automatic wait_grant(output int at);
    int n = 0;
    #1;
    while (!grant_o && n < 5000) begin @(negedge clk); #1; n++; end
    at = cyc;
    if (n >= 5000) chk(1'b0, "R3", "grant timeout", 0, 1);
  endtask

  // request, burst of len cycles, done pulse
  task automatic host_access(input int len, output int g_at, output int d_at);
    @(negedge clk);
    req = 1'b1;
    wait_grant(g_at);
    @(negedge clk);
    req = 1'b0;
    repeat (len) @(negedge clk);
    done_s = 1'b1;
    d_at = cyc;
    @(negedge clk);
    done_s = 1'b0;
  endtask

  task automatic entry_delay(input logic [1:0] code, input int dly, input string rq);
    int g, d, p, s;
    lp_tmo = code;
    exp_q.push_back(C_SREX);
    host_access(3, g, d);
    chk(g - seen_at[C_SREX] == TXSR + 1, "R8", "exit to grant", g - seen_at[C_SREX], TXSR + 1);
    exp_q.push_back(C_PALL);
    exp_q.push_back(C_SREN);
    wait_cmd(C_PALL, p);
    chk(p - d == dly, rq, "entry delay", p - d, dly);
    wait_cmd(C_SREN, s);
  endtask

  initial begin
    int t1, t2, t3, g, d, d2, p, s, a, nb;
    // phase A: refresh only
    period = TW'(40);
    repeat (3) @(negedge clk);
    chk(cmd_o == 3'b000, "R10", "reset cmd", int'(cmd_o), 0);
    chk(cke_o == 1'b1, "R10", "reset cke", int'(cke_o), 1);
    chk(!busy_o && !grant_o, "R10", "reset busy/grant", int'(busy_o), 0);
    rst_ni = 1'b1;
    exp_q.push_back(C_AREF);
    exp_q.push_back(C_AREF);
    wait_cmd(C_AREF, t1);
    wait_cmd(C_AREF, t2);
    chk(t2 - t1 == 40, "R1", "refresh interval", t2 - t1, 40);
    // R3: request lands on a refresh
    req = 1'b1;
    nb = 0;
    #1;
    while (!grant_o && nb < 100) begin
      if (busy_o) nb++;
      @(negedge clk); #1;
    end
    g = cyc;
    chk(nb == TRFC + 1, "R3", "busy cycles", nb, TRFC + 1);
    chk(g - t2 == TRFC + 1, "R3", "grant delay", g - t2, TRFC + 1);
    @(negedge clk);
    req = 1'b0;
    // R2: long burst spans several refresh intervals
    repeat (100) @(negedge clk);
    exp_q.push_back(C_AREF);
    done_s = 1'b1;
    d = cyc;
    @(negedge clk);
    done_s = 1'b0;
    wait_cmd(C_AREF, t3);
    chk(t3 - d == 2, "R2", "refresh after burst", t3 - d, 2);
    chk(!cke_low_seen, "R4", "cke with policy off", int'(cke_low_seen), 0);
    rst_ni = 1'b0;
    exp_q.delete();

    // phase B: self-refresh policy
    period = '1;
    lp_mode = 2'b01;
    lp_tmo = 2'b00;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    exp_q.push_back(C_PALL);
    exp_q.push_back(C_SREN);
    wait_cmd(C_PALL, p);
    wait_cmd(C_SREN, s);
    chk(s - p == 1, "R6", "entry spacing", s - p, 1);
    chk(cke_o == 1'b0, "R6", "cke in entry", int'(cke_o), 0);
    @(negedge clk);
    chk(cke_o == 1'b0 && busy_o, "R8", "asleep cke/busy", int'(busy_o), 1);

    entry_delay(2'b00, 2, "R5");
    entry_delay(2'b11, 2, "R5");
    entry_delay(2'b01, 66, "R5");
    entry_delay(2'b10, 130, "R5");

    // R7: access between precharge and entry
    lp_tmo = 2'b00;
    exp_q.push_back(C_SREX);
    host_access(2, g, d);
    exp_q.push_back(C_PALL);
    exp_q.push_back(C_AREF);
    wait_cmd(C_PALL, p);
    req = 1'b1;
    wait_cmd(C_AREF, a);
    chk(a - p == 1, "R7", "refresh replaces entry", a - p, 1);
    wait_grant(g);
    chk(g - a == TRFC + 1, "R7", "grant after replacement", g - a, TRFC + 1);
    @(negedge clk);
    req = 1'b0;
    repeat (2) @(negedge clk);
    exp_q.push_back(C_PALL);
    exp_q.push_back(C_SREN);
    done_s = 1'b1;
    @(negedge clk);
    done_s = 1'b0;
    wait_cmd(C_SREN, s);

    // R11: second access restarts the idle count
    lp_tmo = 2'b01;
    exp_q.push_back(C_SREX);
    host_access(3, g, d);
    repeat (30) @(negedge clk);
    host_access(3, g, d2);
    exp_q.push_back(C_PALL);
    exp_q.push_back(C_SREN);
    wait_cmd(C_PALL, p);
    chk(p - d2 == 66, "R11", "restarted delay", p - d2, 66);
    wait_cmd(C_SREN, s);

    // R4: policy switched off while active
    exp_q.push_back(C_SREX);
    @(negedge clk);
    req = 1'b1;
    wait_grant(g);
    @(negedge clk);
    req = 1'b0;
    lp_mode = 2'b00;
    lp_tmo = 2'b00;
    done_s = 1'b1;
    @(negedge clk);
    done_s = 1'b0;
    repeat (300) @(negedge clk);
    chk(cke_o == 1'b1, "R4", "cke stays high", int'(cke_o), 1);
    chk(seen_at[C_PALL] == p, "R4", "no precharge", seen_at[C_PALL], p);
    chk(exp_q.size() == 0, "R9", "queue drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule